// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-side controller for one cache line in an invalidation-based directory protocol. It keeps the line's directory entry: a state, an owner pointer and a presence vector with one bit per node. Each incoming protocol message names its kind and its source node. The controller applies the message to the entry and produces the outgoing messages that the message calls for. Those messages are data replies, speculative replies, exclusive or upgrade replies that carry the number of invalidations to expect, NACKs, interventions, invalidations, writeback data forwards and writeback acknowledgements.

The controller never buffers a competing request. While a forwarded operation is still open, the line sits in a busy state and every new request gets a NACK. Replies and acknowledgements go straight to the requester and are not collected at home. A writeback that crosses an intervention is merged with the pending operation: the writeback data is forwarded to the waiting requester and the writer is acknowledged. The input takes one message per cycle through a valid/ready handshake. Outgoing messages leave one per cycle on a single registered channel, and the input is held off until the last one has been issued.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset the entry reads state UNOWNED (code 0) with an all-zero presence vector, `in_ready` is 1 and `out_valid` is 0.
- R2: A READ (input code 0) to an UNOWNED line sets state EXCLUSIVE (code 2), sets the owner to the source, sets the presence vector to only the source's bit, and sends DATA (output code 1) to the source.
- R3: A READ to a SHARED (code 1) line adds the source's presence bit, keeps the state SHARED and sends DATA to the source.
- R4: A READ to an EXCLUSIVE line from a node other than the owner moves the line to BUSY_SHARED (code 3). The pending requester becomes the owner field and the only presence bit. The controller sends INTERVENTION (code 6) to the former owner with the requester in `out_about`, and then SPECULATIVE (code 2) to the requester. A READ or READ_EXCL from the owner itself is answered with DATA and leaves the entry unchanged.
- R5: A READ_EXCL (code 1) to an UNOWNED line behaves like R2. An UPGRADE (code 2) to an UNOWNED line gets a NACK (code 5) to the source and leaves the entry unchanged.
- R6: A READ_EXCL or UPGRADE to a SHARED line sets EXCLUSIVE with the source as owner and sole presence bit. It first sends EXCL_REPLY (code 3, READ_EXCL) or UPGRADE_ACK (code 4, UPGRADE) to the source, with `out_count` equal to the number of other sharers. It then sends one INVALIDATION (code 7) to each other sharer in ascending node order, each with the source in `out_about`.
- R7: An UPGRADE to an EXCLUSIVE line gets a NACK. A READ_EXCL to an EXCLUSIVE line from a non-owner moves the line to BUSY_EXCLUSIVE (code 4) with the requester recorded, sends INVALIDATION to the former owner naming the requester, and then sends SPECULATIVE to the requester.
- R8: In either busy state, a READ, READ_EXCL or UPGRADE gets exactly one NACK to its source and the entry does not change.
- R9: A WRITEBACK (code 3) to an EXCLUSIVE line sets UNOWNED with an empty presence vector and sends WB_ACK (code 8) to the writer.
- R10: A WRITEBACK to a busy line sets SHARED from BUSY_SHARED, or EXCLUSIVE from BUSY_EXCLUSIVE, with the pending requester as owner and sole sharer. It sends WB_FORWARD (code 9) to the requester and then WB_ACK to the writer.
- R11: A REVISION_SHARE (code 4) to a busy line sets SHARED with presence bits for both the pending requester and the former owner. A REVISION_XFER (code 5) to a busy line sets EXCLUSIVE with the requester as owner. Neither sends any message.
- R12: A WRITEBACK to an UNOWNED or SHARED line, a revision to a non-busy line, and input codes 6 and 7 send no message and change nothing.
- R13: The first message of an accepted input appears in the cycle after acceptance, the rest follow one per cycle, and `in_ready` is 0 until the cycle in which the last message is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller can accept a message this cycle |
| in_kind | input | 3 | Incoming message kind |
| in_src | input | 4 | Node that sent the incoming message |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 4 | Outgoing message kind |
| out_dest | output | 4 | Destination node of the outgoing message |
| out_about | output | 4 | Requester named in an intervention or invalidation |
| out_count | output | 5 | Invalidations to expect (exclusive or upgrade reply) |
| dir_state | output | 3 | Directory state of the line |
| dir_owner | output | 4 | Owner pointer (owner or pending requester) |
| dir_sharers | output | 16 | Presence vector, one bit per node |

## Verification
A corrupted directory entry shows up at the ports in the very next message for the line. A wrong owner pointer sends an intervention or invalidation to the wrong node. A lost presence bit shrinks the invalidation count and drops one invalidation from the sequence. A busy state that clears too early lets a competing request through in place of the NACK. Since every message lands on the output one cycle after acceptance, or one cycle after the message before it, each such fault is visible within the cycles spent on the message that exposes it, and the directory outputs show it right after that edge.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  // incoming message codes
  localparam logic [2:0] IK_READ   = 3'd0;
  localparam logic [2:0] IK_RDEX   = 3'd1;
  localparam logic [2:0] IK_UPGR   = 3'd2;
  localparam logic [2:0] IK_WBACK  = 3'd3;
  localparam logic [2:0] IK_REV_SH = 3'd4;
  localparam logic [2:0] IK_REV_XF = 3'd5;

  // outgoing message codes
  localparam logic [3:0] MK_NONE   = 4'd0;
  localparam logic [3:0] MK_DATA   = 4'd1;
  localparam logic [3:0] MK_SPEC   = 4'd2;
  localparam logic [3:0] MK_EXCNT  = 4'd3;
  localparam logic [3:0] MK_UPCNT  = 4'd4;
  localparam logic [3:0] MK_NACK   = 4'd5;
  localparam logic [3:0] MK_INTERV = 4'd6;
  localparam logic [3:0] MK_INVAL  = 4'd7;
  localparam logic [3:0] MK_WBACK  = 4'd8;
  localparam logic [3:0] MK_WBFWD  = 4'd9;

  typedef enum logic [2:0] {
    ST_UNOWNED = 3'd0,
    ST_SHARED  = 3'd1,
    ST_EXCL    = 3'd2,
    ST_BUSY_SH = 3'd3,
    ST_BUSY_EX = 3'd4
  } dir_state_e;

endpackage

// File: rtl/dir_lowbit_pick.sv
module dir_lowbit_pick #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] lower_any;

  assign lower_any[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < W; gi++) begin : g_chain
      assign lower_any[gi] = lower_any[gi-1] | vec[gi-1];
    end
  endgenerate

  assign onehot = vec & ~lower_any;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/dir_entry_fsm.sv
module dir_entry_fsm
  import dir_home_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NODE_W = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [2:0]        kind,
  input  logic [NODE_W-1:0] src,
  output dir_state_e        st_q,
  output logic [NODE_W-1:0] owner_q,
  output logic [NODES-1:0]  sharers_q,
  output logic              m0_v,
  output logic [3:0]        m0_kind,
  output logic [NODE_W-1:0] m0_dest,
  output logic [NODE_W-1:0] m0_about,
  output logic [CNT_W-1:0]  m0_cnt,
  output logic              m1_v,
  output logic [3:0]        m1_kind,
  output logic [NODE_W-1:0] m1_dest,
  output logic [NODES-1:0]  inv_mask,
  output logic [NODE_W-1:0] inv_about
);
  dir_state_e        st_d;
  logic [NODE_W-1:0] owner_d, prev_q, prev_d;
  logic [NODES-1:0]  sharers_d, src_bit, prev_bit, others;
  logic [CNT_W-1:0]  other_cnt;
  logic              is_req, busy;

  assign src_bit  = {{(NODES-1){1'b0}}, 1'b1} << src;
  assign prev_bit = {{(NODES-1){1'b0}}, 1'b1} << prev_q;
  assign others   = sharers_q & ~src_bit;
  assign is_req   = (kind == IK_READ) || (kind == IK_RDEX) || (kind == IK_UPGR);
  assign busy     = (st_q == ST_BUSY_SH) || (st_q == ST_BUSY_EX);

  always_comb begin
    other_cnt = '0;
    for (int i = 0; i < NODES; i++) other_cnt = other_cnt + CNT_W'(others[i]);
  end

  always_comb begin
    st_d      = st_q;
    owner_d   = owner_q;
    sharers_d = sharers_q;
    prev_d    = prev_q;
    m0_v      = 1'b0;
    m0_kind   = MK_NONE;
    m0_dest   = src;
    m0_about  = '0;
    m0_cnt    = '0;
    m1_v      = 1'b0;
    m1_kind   = MK_NONE;
    m1_dest   = src;
    inv_mask  = '0;
    inv_about = src;
    case (st_q)
      ST_UNOWNED: begin
        if (kind == IK_READ || kind == IK_RDEX) begin
          st_d = ST_EXCL; owner_d = src; sharers_d = src_bit;
          m0_v = 1'b1; m0_kind = MK_DATA;
        end else if (kind == IK_UPGR) begin
          m0_v = 1'b1; m0_kind = MK_NACK;
        end
      end
      ST_SHARED: begin
        if (kind == IK_READ) begin
          sharers_d = sharers_q | src_bit;
          m0_v = 1'b1; m0_kind = MK_DATA;
        end else if (kind == IK_RDEX || kind == IK_UPGR) begin
          st_d = ST_EXCL; owner_d = src; sharers_d = src_bit;
          m0_v = 1'b1;
          m0_kind = (kind == IK_RDEX) ? MK_EXCNT : MK_UPCNT;
          m0_cnt = other_cnt;
          inv_mask = others;
        end
      end
      ST_EXCL: begin
        if ((kind == IK_READ || kind == IK_RDEX) && src == owner_q) begin
          m0_v = 1'b1; m0_kind = MK_DATA;
        end else if (kind == IK_READ || kind == IK_RDEX) begin
          st_d = (kind == IK_READ) ? ST_BUSY_SH : ST_BUSY_EX;
          prev_d = owner_q; owner_d = src; sharers_d = src_bit;
          m0_v = 1'b1;
          m0_kind = (kind == IK_READ) ? MK_INTERV : MK_INVAL;
          m0_dest = owner_q; m0_about = src;
          m1_v = 1'b1; m1_kind = MK_SPEC; m1_dest = src;
        end else if (kind == IK_UPGR) begin
          m0_v = 1'b1; m0_kind = MK_NACK;
        end else if (kind == IK_WBACK) begin
          st_d = ST_UNOWNED; sharers_d = '0;
          m0_v = 1'b1; m0_kind = MK_WBACK;
        end
      end
      ST_BUSY_SH, ST_BUSY_EX: begin
        if (is_req) begin
          m0_v = 1'b1; m0_kind = MK_NACK;
        end else if (kind == IK_WBACK) begin
          st_d = (st_q == ST_BUSY_SH) ? ST_SHARED : ST_EXCL;
          m0_v = 1'b1; m0_kind = MK_WBFWD; m0_dest = owner_q;
          m1_v = 1'b1; m1_kind = MK_WBACK; m1_dest = src;
        end else if (kind == IK_REV_SH) begin
          st_d = ST_SHARED; sharers_d = sharers_q | prev_bit;
        end else if (kind == IK_REV_XF) begin
          st_d = ST_EXCL;
        end
      end
      default: st_d = ST_UNOWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_UNOWNED;
      owner_q   <= '0;
      prev_q    <= '0;
      sharers_q <= '0;
    end else if (acc) begin
      st_q      <= st_d;
      owner_q   <= owner_d;
      prev_q    <= prev_d;
      sharers_q <= sharers_d;
    end
  end

  // R8: a request met in a busy state leaves the entry untouched
  a_r8_busy_entry_held: assert property (@(posedge clk) disable iff (rst)
    (acc && busy && is_req) |=> (st_q == $past(st_q)) && (sharers_q == $past(sharers_q)));
  // R2: an exclusive line has exactly one presence bit, the owner's
  a_r2_excl_single_owner: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXCL) |-> ($countones(sharers_q) == 1) && sharers_q[owner_q]);
  // R9: an unowned line has no sharers
  a_r9_unowned_empty: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_UNOWNED) |-> (sharers_q == '0));
endmodule

// File: rtl/dir_msg_seq.sv
module dir_msg_seq
  import dir_home_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NODE_W = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              m0_v,
  input  logic [3:0]        m0_kind,
  input  logic [NODE_W-1:0] m0_dest,
  input  logic [NODE_W-1:0] m0_about,
  input  logic [CNT_W-1:0]  m0_cnt,
  input  logic              m1_v,
  input  logic [3:0]        m1_kind,
  input  logic [NODE_W-1:0] m1_dest,
  input  logic [NODES-1:0]  inv_mask,
  input  logic [NODE_W-1:0] inv_about,
  output logic              idle,
  output logic              out_valid,
  output logic [3:0]        out_kind,
  output logic [NODE_W-1:0] out_dest,
  output logic [NODE_W-1:0] out_about,
  output logic [CNT_W-1:0]  out_count
);
  logic              p1_v;
  logic [3:0]        p1_kind;
  logic [NODE_W-1:0] p1_dest;
  logic [NODES-1:0]  mask_q, pick_hot;
  logic [NODE_W-1:0] about_q, pick_idx;

  dir_lowbit_pick #(.W(NODES), .IDX_W(NODE_W)) u_pick (
    .vec    (mask_q),
    .onehot (pick_hot),
    .idx    (pick_idx)
  );

  assign idle = !p1_v && (mask_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= MK_NONE;
      out_dest  <= '0;
      out_about <= '0;
      out_count <= '0;
      p1_v      <= 1'b0;
      p1_kind   <= MK_NONE;
      p1_dest   <= '0;
      mask_q    <= '0;
      about_q   <= '0;
    end else if (load) begin
      out_valid <= m0_v;
      out_kind  <= m0_kind;
      out_dest  <= m0_dest;
      out_about <= m0_about;
      out_count <= m0_cnt;
      p1_v      <= m0_v && m1_v;
      p1_kind   <= m1_kind;
      p1_dest   <= m1_dest;
      mask_q    <= m0_v ? inv_mask : '0;
      about_q   <= inv_about;
    end else if (p1_v) begin
      out_valid <= 1'b1;
      out_kind  <= p1_kind;
      out_dest  <= p1_dest;
      out_about <= '0;
      out_count <= '0;
      p1_v      <= 1'b0;
    end else if (mask_q != '0) begin
      out_valid <= 1'b1;
      out_kind  <= MK_INVAL;
      out_dest  <= pick_idx;
      out_about <= about_q;
      out_count <= '0;
      mask_q    <= mask_q & ~pick_hot;
    end else begin
      out_valid <= 1'b0;
      out_kind  <= MK_NONE;
    end
  end

  // R13: while input is held off, a message is issued every cycle
  a_r13_stall_emits: assert property (@(posedge clk) disable iff (rst)
    !idle |=> out_valid);
  // R6: an invalidation is never sent to the node it names
  a_r6_inval_not_self: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == MK_INVAL) |-> (out_about != out_dest));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NODE_W = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [NODE_W-1:0] in_src,
  output logic              out_valid,
  output logic [3:0]        out_kind,
  output logic [NODE_W-1:0] out_dest,
  output logic [NODE_W-1:0] out_about,
  output logic [CNT_W-1:0]  out_count,
  output logic [2:0]        dir_state,
  output logic [NODE_W-1:0] dir_owner,
  output logic [NODES-1:0]  dir_sharers
);
  dir_state_e        st_q;
  logic              acc, idle;
  logic              m0_v, m1_v;
  logic [3:0]        m0_kind, m1_kind;
  logic [NODE_W-1:0] m0_dest, m0_about, m1_dest, inv_about;
  logic [CNT_W-1:0]  m0_cnt;
  logic [NODES-1:0]  inv_mask;

  assign in_ready  = idle;
  assign acc       = in_valid && idle;
  assign dir_state = st_q;

  dir_entry_fsm #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .kind      (in_kind),
    .src       (in_src),
    .st_q      (st_q),
    .owner_q   (dir_owner),
    .sharers_q (dir_sharers),
    .m0_v      (m0_v),
    .m0_kind   (m0_kind),
    .m0_dest   (m0_dest),
    .m0_about  (m0_about),
    .m0_cnt    (m0_cnt),
    .m1_v      (m1_v),
    .m1_kind   (m1_kind),
    .m1_dest   (m1_dest),
    .inv_mask  (inv_mask),
    .inv_about (inv_about)
  );

  dir_msg_seq #(.NODES(NODES), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (acc),
    .m0_v      (m0_v),
    .m0_kind   (m0_kind),
    .m0_dest   (m0_dest),
    .m0_about  (m0_about),
    .m0_cnt    (m0_cnt),
    .m1_v      (m1_v),
    .m1_kind   (m1_kind),
    .m1_dest   (m1_dest),
    .inv_mask  (inv_mask),
    .inv_about (inv_about),
    .idle      (idle),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_dest  (out_dest),
    .out_about (out_about),
    .out_count (out_count)
  );

  // R8: a request accepted while busy is answered by a NACK to its sender
  a_r8_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (acc && (dir_state == 3'd3 || dir_state == 3'd4) && in_kind <= 3'd2)
    |=> out_valid && (out_kind == MK_NACK) && (out_dest == $past(in_src)));
  // R1: nothing is emitted in the cycle after a reset cycle
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [3:0]  in_src = '0;
  logic        out_valid;
  logic [3:0]  out_kind, out_dest, out_about;
  logic [4:0]  out_count;
  logic [2:0]  dir_state;
  logic [3:0]  dir_owner;
  logic [15:0] dir_sharers;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [3:0] g_kind  [0:19];
  logic [3:0] g_dest  [0:19];
  logic [3:0] g_about [0:19];
  logic [4:0] g_cnt   [0:19];
  logic       g_rdy   [0:19];
  int         nmsg;

  always #4 clk = ~clk;

  dir_home_ctrl u_dir_home_ctrl (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_kind (in_kind), .in_src (in_src), .out_valid (out_valid),
    .out_kind (out_kind), .out_dest (out_dest), .out_about (out_about),
    .out_count (out_count), .dir_state (dir_state), .dir_owner (dir_owner),
    .dir_sharers (dir_sharers)
  );

  // fields: req kind src | state owner sharers | nmsg kind dest about count
  localparam int NV = 24;
  localparam logic [53:0] VEC [NV] = '{
    {4'd2,  3'd0, 4'd3,  3'd2, 4'd3,  16'h0008, 3'd1, 4'd1, 4'd3,  4'd0,  5'd0},
    {4'd4,  3'd0, 4'd3,  3'd2, 4'd3,  16'h0008, 3'd1, 4'd1, 4'd3,  4'd0,  5'd0},
    {4'd7,  3'd2, 4'd5,  3'd2, 4'd3,  16'h0008, 3'd1, 4'd5, 4'd5,  4'd0,  5'd0},
    {4'd4,  3'd0, 4'd5,  3'd3, 4'd5,  16'h0020, 3'd2, 4'd6, 4'd3,  4'd5,  5'd0},
    {4'd8,  3'd1, 4'd7,  3'd3, 4'd5,  16'h0020, 3'd1, 4'd5, 4'd7,  4'd0,  5'd0},
    {4'd11, 3'd4, 4'd3,  3'd1, 4'd0,  16'h0028, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd3,  3'd0, 4'd0,  3'd1, 4'd0,  16'h0029, 3'd1, 4'd1, 4'd0,  4'd0,  5'd0},
    {4'd6,  3'd2, 4'd5,  3'd2, 4'd5,  16'h0020, 3'd3, 4'd4, 4'd5,  4'd0,  5'd2},
    {4'd7,  3'd1, 4'd9,  3'd4, 4'd9,  16'h0200, 3'd2, 4'd7, 4'd5,  4'd9,  5'd0},
    {4'd10, 3'd3, 4'd5,  3'd2, 4'd9,  16'h0200, 3'd2, 4'd9, 4'd9,  4'd0,  5'd0},
    {4'd9,  3'd3, 4'd9,  3'd0, 4'd0,  16'h0000, 3'd1, 4'd8, 4'd9,  4'd0,  5'd0},
    {4'd5,  3'd2, 4'd2,  3'd0, 4'd0,  16'h0000, 3'd1, 4'd5, 4'd2,  4'd0,  5'd0},
    {4'd5,  3'd1, 4'd2,  3'd2, 4'd2,  16'h0004, 3'd1, 4'd1, 4'd2,  4'd0,  5'd0},
    {4'd4,  3'd0, 4'd15, 3'd3, 4'd15, 16'h8000, 3'd2, 4'd6, 4'd2,  4'd15, 5'd0},
    {4'd10, 3'd3, 4'd2,  3'd1, 4'd0,  16'h8000, 3'd2, 4'd9, 4'd15, 4'd0,  5'd0},
    {4'd12, 3'd3, 4'd4,  3'd1, 4'd0,  16'h8000, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd12, 3'd5, 4'd1,  3'd1, 4'd0,  16'h8000, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd12, 3'd7, 4'd1,  3'd1, 4'd0,  16'h8000, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd6,  3'd1, 4'd15, 3'd2, 4'd15, 16'h8000, 3'd1, 4'd3, 4'd15, 4'd0,  5'd0},
    {4'd4,  3'd0, 4'd1,  3'd3, 4'd1,  16'h0002, 3'd2, 4'd6, 4'd15, 4'd1,  5'd0},
    {4'd11, 3'd5, 4'd15, 3'd2, 4'd1,  16'h0002, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd7,  3'd1, 4'd6,  3'd4, 4'd6,  16'h0040, 3'd2, 4'd7, 4'd1,  4'd6,  5'd0},
    {4'd11, 3'd5, 4'd1,  3'd2, 4'd6,  16'h0040, 3'd0, 4'd0, 4'd0,  4'd0,  5'd0},
    {4'd9,  3'd3, 4'd6,  3'd0, 4'd0,  16'h0000, 3'd1, 4'd8, 4'd6,  4'd0,  5'd0}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive one message, then record every message it causes
  task automatic apply(input logic [2:0] k, input logic [3:0] s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_src = s;
    @(posedge clk);
    #1 in_valid = 1'b0;
    nmsg = 0;
    @(negedge clk);
    while (out_valid && nmsg < 20) begin
      g_kind[nmsg] = out_kind; g_dest[nmsg] = out_dest;
      g_about[nmsg] = out_about; g_cnt[nmsg] = out_count;
      g_rdy[nmsg] = in_ready;
      nmsg++;
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state();
    chk(dir_state == 3'd0, "R1", "state", dir_state, 0);
    chk(dir_sharers == 16'h0, "R1", "sharers", dir_sharers, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
  endtask

  task automatic check_msg(input int i, input string tag, input logic [3:0] k,
                           input logic [3:0] d);
    chk(g_kind[i] == k, tag, $sformatf("msg%0d kind", i), g_kind[i], k);
    chk(g_dest[i] == d, tag, $sformatf("msg%0d dest", i), g_dest[i], d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check_reset_state();  // R1

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13
    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[53:50]);
      apply(v[49:47], v[46:43]);
      chk(dir_state == v[42:40], tag, $sformatf("v%0d state", i), dir_state, v[42:40]);
      if (v[42:40] >= 3'd2)
        chk(dir_owner == v[39:36], tag, $sformatf("v%0d owner", i), dir_owner, v[39:36]);
      chk(dir_sharers == v[35:20], tag, $sformatf("v%0d sharers", i), dir_sharers, v[35:20]);
      chk(nmsg == int'(v[19:17]), tag, $sformatf("v%0d msg count", i), nmsg, v[19:17]);
      if (nmsg > 0) begin
        check_msg(0, tag, v[16:13], v[12:9]);
        if (v[16:13] == 4'd6 || v[16:13] == 4'd7)
          chk(g_about[0] == v[8:5], tag, $sformatf("v%0d about", i), g_about[0], v[8:5]);
        if (v[16:13] == 4'd3 || v[16:13] == 4'd4)
          chk(g_cnt[0] == v[4:0], tag, $sformatf("v%0d count", i), g_cnt[0], v[4:0]);
        // R13: input held off until the last message is presented
        for (int m = 0; m < nmsg; m++)
          chk(g_rdy[m] == (m == nmsg - 1), "R13", $sformatf("v%0d ready at msg%0d", i, m),
              g_rdy[m], (m == nmsg - 1));
      end
    end

    // directed: R6 full invalidation sequence, ascending order
    apply(3'd0, 4'd4);
    apply(3'd0, 4'd10);
    apply(3'd4, 4'd4);
    apply(3'd0, 4'd0);
    apply(3'd0, 4'd15);
    chk(dir_sharers == 16'h8411, "R3", "sharers before write", dir_sharers, 16'h8411);
    apply(3'd1, 4'd10);
    chk(nmsg == 4, "R6", "message count", nmsg, 4);
    check_msg(0, "R6", 4'd3, 4'd10);
    chk(g_cnt[0] == 5'd3, "R6", "inval count", g_cnt[0], 3);
    check_msg(1, "R6", 4'd7, 4'd0);
    check_msg(2, "R6", 4'd7, 4'd4);
    check_msg(3, "R6", 4'd7, 4'd15);
    chk(g_about[3] == 4'd10, "R6", "inval names requester", g_about[3], 10);
    chk(dir_owner == 4'd10 && dir_sharers == 16'h0400, "R6", "new owner", dir_owner, 10);

    // directed: R10 merged writeback acknowledges the writer second
    apply(3'd0, 4'd2);
    apply(3'd3, 4'd10);
    chk(nmsg == 2, "R10", "message count", nmsg, 2);
    check_msg(0, "R10", 4'd9, 4'd2);
    check_msg(1, "R10", 4'd8, 4'd10);
    chk(dir_state == 3'd1 && dir_sharers == 16'h0004, "R10", "shared with requester",
        dir_sharers, 16'h0004);

    // directed: reset in mid-operation returns to the empty entry (R1)
    apply(3'd1, 4'd7);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule